// File: doc/BRIEF.md
# Multiplexed Grid PWM Dimmer

This block strobes the grids of a vacuum fluorescent panel one after another and gates its segment lines with a programmable pulse width. Every grid slot lasts a fixed number of clocks (2048 by default). Each slot opens with a short forced-dark gap of two clocks. After the gap, the segments of the active grid show their display bits for a time set by a binary brightness code, and stay dark for the rest of the slot.

A strap input selects between two multiplex ratios. With three grids, each grid drives 56 segments and the shared pin acts as grid 3. With two grids, each grid drives 57 segments and the shared pin acts as segment 57.

Four of the upper segment pins can each be switched into a static general-purpose output. Such a pin then bypasses the multiplex and the dimmer. A blank/reset input and a sleep input both darken the panel and park the slot timing. Blank also clears the general-purpose pins; sleep leaves them driving.

Top module: `vfd_grid_dimmer`

## Requirements
- R1: After the first clock edge that samples blank_n high and sleep low, grid_o[0] is active for SLOT_CLKS clocks, then the next grid follows. The grids cycle in order 1, 2(, 3). At most one grid is active at any time.
- R2: With duty_half low there are three grids: grid3_seg57_o is grid 3, and seg_o carries 56 segments. With duty_half high there are two grids: grid3_seg57_o is segment 57 of the active grid.
- R3: Within a slot at position p (0 = first clock), the segments may be lit only when BLANK_CLKS <= p < BLANK_CLKS + code*(SLOT_CLKS/2^DIM_W). The opening gap does not depend on the code.
- R4: Brightness codes above 2^DIM_W-2 behave exactly like 2^DIM_W-2 (1022 at the default width).
- R5: A brightness code of 0 keeps every dimmed segment dark.
- R6: While lit during grid k (0-based), segment index n shows disp_bits[n+56k] in three-grid mode. In two-grid mode it shows disp_bits[n+57k], and the shared pin shows disp_bits[56+57k].
- R7: When gp_en[i] is set, seg_o[55-i] continuously shows disp_bits[55-i]. The dimmer window, the grid order and sleep do not affect it.
- R8: While sleep is high, all grid outputs and dimmed segment outputs are low. Leaving sleep restarts the timing at position 0 of grid 1.
- R9: While blank_n is low, every output is low, including the general-purpose pins. Releasing blank_n restarts the timing at position 0 of grid 1.
- R10: While rst_n is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_n | input | 1 | Active-low blank/reset of the display |
| sleep | input | 1 | Sleep state, darkens the multiplex |
| duty_half | input | 1 | Strap: 0 = three grids, 1 = two grids |
| dim_code | input | DIM_W | Brightness code, bit 0 is the LSB |
| gp_en | input | 4 | General-purpose enables, bit i controls seg_o[55-i] |
| disp_bits | input | 3*SEG_N | Latched display bits |
| grid_o | output | 2 | Grid 1 and grid 2 strobes |
| grid3_seg57_o | output | 1 | Grid 3 strobe or segment 57 |
| seg_o | output | SEG_N | Segment outputs |

## Verification
The properties assume that dim_code, duty_half and gp_en stay constant while the multiplex runs. They also assume that BLANK_CLKS is at least one and that the widest window ends inside the slot. The bench keeps to these assumptions: it changes the configuration and the display bits only while blank_n is low. It then releases blank_n and compares every clock of more than a full frame against a slot position and grid index that it computes itself. A reduced slot of 32 clocks with a 4-bit code makes it possible to sweep every code in both duty modes.

// File: rtl/vfd_dim_pkg.sv
package vfd_dim_pkg;
    typedef enum logic [1:0] {
        ST_DARK,
        ST_GAP,
        ST_LIT,
        ST_TAIL
    } slot_state_e;

    localparam int GRID_IDX_W = 2;
    localparam int GP_N       = 4;
endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
    parameter int SLOT_CLKS = 2048,
    localparam int POS_W    = $clog2(SLOT_CLKS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 run,
    input  logic                                 half,
    output logic [POS_W-1:0]                     pos_n,
    output logic [vfd_dim_pkg::GRID_IDX_W-1:0]   idx_n,
    output logic                                 wrap_n
);
    import vfd_dim_pkg::*;

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_CLKS - 1);

    logic [POS_W-1:0]      pos_q;
    logic [GRID_IDX_W-1:0] idx_q;
    logic [GRID_IDX_W-1:0] idx_last;

    assign idx_last = half ? 2'd1 : 2'd2;

    always_comb begin
        wrap_n = 1'b0;
        pos_n  = pos_q;
        idx_n  = idx_q;
        if (!run) begin
            pos_n = POS_LAST;
            idx_n = 2'd2;
        end else if (pos_q == POS_LAST) begin
            wrap_n = 1'b1;
            pos_n  = '0;
            idx_n  = (idx_q >= idx_last) ? 2'd0 : idx_q + 2'd1;
        end else begin
            pos_n = pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= POS_LAST;
            idx_q <= 2'd2;
        end else begin
            pos_q <= pos_n;
            idx_q <= idx_n;
        end
    end
endmodule

// File: rtl/vfd_dim_fsm.sv
module vfd_dim_fsm #(
    parameter int SLOT_CLKS  = 2048,
    parameter int DIM_W      = 10,
    parameter int BLANK_CLKS = 2,
    localparam int POS_W     = $clog2(SLOT_CLKS),
    localparam int EW        = POS_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             run,
    input  logic [POS_W-1:0]                 pos_n,
    input  logic                             wrap_n,
    input  logic [DIM_W-1:0]                 dim_code,
    output vfd_dim_pkg::slot_state_e         state_d
);
    import vfd_dim_pkg::*;

    localparam int SCALE = SLOT_CLKS >> DIM_W;
    localparam logic [DIM_W-1:0] CODE_MAX = DIM_W'((1 << DIM_W) - 2);

    slot_state_e       state_q;
    logic [DIM_W-1:0]  code_sat;
    logic [EW-1:0]     win_end;
    logic [EW-1:0]     pos_ext;
    logic              past_gap;
    logic              in_win;

    assign code_sat = (dim_code > CODE_MAX) ? CODE_MAX : dim_code;
    assign win_end  = EW'(BLANK_CLKS) + EW'(code_sat) * EW'(SCALE);
    assign pos_ext  = {1'b0, pos_n};
    assign past_gap = pos_ext >= EW'(BLANK_CLKS);
    assign in_win   = past_gap && (pos_ext < win_end);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DARK: begin
                if (run) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (past_gap) state_d = in_win ? ST_LIT : ST_TAIL;
            end
            ST_LIT: begin
                if (wrap_n)       state_d = ST_GAP;
                else if (!in_win) state_d = ST_TAIL;
            end
            ST_TAIL: begin
                if (wrap_n) state_d = ST_GAP;
            end
            default: state_d = ST_DARK;
        endcase
        if (!run) state_d = ST_DARK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DARK;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/vfd_seg_row.sv
module vfd_seg_row #(
    parameter int SEG_N    = 56,
    localparam int DISP_W  = 3 * SEG_N
) (
    input  logic                                half,
    input  logic [vfd_dim_pkg::GRID_IDX_W-1:0]  idx,
    input  logic [DISP_W-1:0]                   disp,
    output logic [SEG_N:0]                      row
);
    for (genvar n = 0; n <= SEG_N; n++) begin : g_col
        logic third_bit;
        logic half_bit;
        if (n < SEG_N) begin : g_third
            always_comb begin
                unique case (idx)
                    2'd0:    third_bit = disp[n];
                    2'd1:    third_bit = disp[n + SEG_N];
                    2'd2:    third_bit = disp[n + 2 * SEG_N];
                    default: third_bit = 1'b0;
                endcase
            end
        end else begin : g_none
            assign third_bit = 1'b0;
        end
        assign half_bit = (idx == 2'd0) ? disp[n] :
                          (idx == 2'd1) ? disp[n + SEG_N + 1] : 1'b0;
        assign row[n] = half ? half_bit : third_bit;
    end
endmodule

// File: rtl/vfd_grid_dimmer.sv
module vfd_grid_dimmer #(
    parameter int SLOT_CLKS  = 2048,
    parameter int DIM_W      = 10,
    parameter int BLANK_CLKS = 2,
    parameter int SEG_N      = 56,
    localparam int DISP_W    = 3 * SEG_N,
    localparam int POS_W     = $clog2(SLOT_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank_n,
    input  logic              sleep,
    input  logic              duty_half,
    input  logic [DIM_W-1:0]  dim_code,
    input  logic [3:0]        gp_en,
    input  logic [DISP_W-1:0] disp_bits,
    output logic [1:0]        grid_o,
    output logic              grid3_seg57_o,
    output logic [SEG_N-1:0]  seg_o
);
    import vfd_dim_pkg::*;

    logic                  run;
    logic [POS_W-1:0]      pos_n;
    logic [GRID_IDX_W-1:0] idx_n;
    logic                  wrap_n;
    slot_state_e           state_d;
    logic [SEG_N:0]        row;
    logic                  lit_d;
    logic                  on_d;
    logic [SEG_N-1:0]      seg_d;
    logic [1:0]            grid_d;
    logic                  shared_d;

    assign run = blank_n & ~sleep;

    vfd_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .half   (duty_half),
        .pos_n  (pos_n),
        .idx_n  (idx_n),
        .wrap_n (wrap_n)
    );

    vfd_dim_fsm #(
        .SLOT_CLKS  (SLOT_CLKS),
        .DIM_W      (DIM_W),
        .BLANK_CLKS (BLANK_CLKS)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .pos_n    (pos_n),
        .wrap_n   (wrap_n),
        .dim_code (dim_code),
        .state_d  (state_d)
    );

    vfd_seg_row #(.SEG_N(SEG_N)) i_row (
        .half (duty_half),
        .idx  (idx_n),
        .disp (disp_bits),
        .row  (row)
    );

    assign lit_d = (state_d == ST_LIT);
    assign on_d  = (state_d != ST_DARK);

    always_comb begin
        grid_d[0] = on_d && (idx_n == 2'd0);
        grid_d[1] = on_d && (idx_n == 2'd1);
        shared_d  = duty_half ? (lit_d & row[SEG_N]) : (on_d && (idx_n == 2'd2));
        seg_d     = lit_d ? row[SEG_N-1:0] : '0;
        for (int i = 0; i < GP_N; i++) begin
            if (gp_en[i]) seg_d[SEG_N-1-i] = blank_n & disp_bits[SEG_N-1-i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grid_o        <= '0;
            grid3_seg57_o <= 1'b0;
            seg_o         <= '0;
        end else begin
            grid_o        <= grid_d;
            grid3_seg57_o <= shared_d;
            seg_o         <= seg_d;
        end
    end
endmodule

// File: rtl/vfd_grid_dimmer_chk.sv
module vfd_grid_dimmer_chk #(
    parameter int SLOT_CLKS  = 2048,
    parameter int DIM_W      = 10,
    parameter int BLANK_CLKS = 2,
    parameter int SEG_N      = 56,
    localparam int DISP_W    = 3 * SEG_N
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blank_n,
    input logic              sleep,
    input logic              duty_half,
    input logic [DIM_W-1:0]  dim_code,
    input logic [3:0]        gp_en,
    input logic [DISP_W-1:0] disp_bits,
    input logic [1:0]        grid_o,
    input logic              grid3_seg57_o,
    input logic [SEG_N-1:0]  seg_o
);
    logic [SEG_N-1:0] gp_mask;

    always_comb begin
        gp_mask = '0;
        for (int i = 0; i < 4; i++) gp_mask[SEG_N-1-i] = gp_en[i];
    end

    AST_GRID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grid_o, grid3_seg57_o & ~duty_half})); // R1

    AST_SHARED_IS_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
        duty_half && $stable(duty_half) && grid3_seg57_o |-> grid_o != 2'b00); // R2

    AST_SLOT_OPENS_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grid_o[0]) |-> (seg_o & ~$past(gp_mask)) == '0); // R3

    AST_ZERO_CODE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        dim_code == '0 |=> (seg_o & ~$past(gp_mask)) == '0); // R5

    AST_GP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        gp_en[0] && blank_n |=> seg_o[SEG_N-1] == $past(disp_bits[SEG_N-1])); // R7

    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> grid_o == 2'b00 && (seg_o & ~$past(gp_mask)) == '0); // R8

    AST_BLANK_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |=> grid_o == 2'b00 && !grid3_seg57_o && seg_o == '0); // R9
endmodule

bind vfd_grid_dimmer vfd_grid_dimmer_chk #(
    .SLOT_CLKS  (SLOT_CLKS),
    .DIM_W      (DIM_W),
    .BLANK_CLKS (BLANK_CLKS),
    .SEG_N      (SEG_N)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .blank_n       (blank_n),
    .sleep         (sleep),
    .duty_half     (duty_half),
    .dim_code      (dim_code),
    .gp_en         (gp_en),
    .disp_bits     (disp_bits),
    .grid_o        (grid_o),
    .grid3_seg57_o (grid3_seg57_o),
    .seg_o         (seg_o)
);

// File: tb/test_vfd_grid_dimmer.sv
module test_vfd_grid_dimmer;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT  = 32;
    localparam int DW    = 4;
    localparam int BLANK = 2;
    localparam int SEGN  = 56;
    localparam int DISPW = 3 * SEGN;
    localparam int SCALE = SLOT >> DW;
    localparam int CMAX  = (1 << DW) - 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             blank_n = 1'b0;
    logic             sleep = 1'b0;
    logic             duty_half = 1'b0;
    logic [DW-1:0]    dim_code = '0;
    logic [3:0]       gp_en = '0;
    logic [DISPW-1:0] disp_bits = '0;
    logic [1:0]       grid_o;
    logic             grid3_seg57_o;
    logic [SEGN-1:0]  seg_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vfd_grid_dimmer #(
        .SLOT_CLKS(SLOT), .DIM_W(DW), .BLANK_CLKS(BLANK), .SEG_N(SEGN)
    ) i_vfd_grid_dimmer (
        .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .sleep(sleep),
        .duty_half(duty_half), .dim_code(dim_code), .gp_en(gp_en),
        .disp_bits(disp_bits), .grid_o(grid_o),
        .grid3_seg57_o(grid3_seg57_o), .seg_o(seg_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [SEGN-1:0] gpmask(input logic [3:0] g);
        logic [SEGN-1:0] m = '0;
        for (int i = 0; i < 4; i++) m[SEGN-1-i] = g[i];
        return m;
    endfunction

    function automatic logic win(input int p, input int code);
        int c = (code > CMAX) ? CMAX : code;
        return (p >= BLANK) && (p < BLANK + c * SCALE);
    endfunction

    function automatic logic [SEGN-1:0] exp_row(input int p, input int g, input logic half,
                                                input int code, input logic [DISPW-1:0] d);
        logic [SEGN-1:0] v = '0;
        int stride = half ? SEGN + 1 : SEGN;
        if (win(p, code))
            for (int n = 0; n < SEGN; n++) v[n] = d[n + stride * g];
        return v;
    endfunction

    task automatic new_disp();
        for (int b = 0; b < DISPW; b++) disp_bits[b] = 1'($urandom_range(0, 1));
    endtask

    task automatic sweep(input logic half, input int code, input logic [3:0] g);
        int ng = half ? 2 : 3;
        logic [SEGN-1:0] m = gpmask(g);
        string rq;
        @(negedge clk);
        blank_n = 1'b0;
        duty_half = half;
        dim_code = DW'(code);
        gp_en = g;
        new_disp();
        @(negedge clk);
        blank_n = 1'b1;
        rq = (code == 0) ? "R5" : (code > CMAX) ? "R4/R6" : "R3/R6";
        for (int k = 0; k < (ng + 1) * SLOT; k++) begin
            int p = k % SLOT;
            int gi = (k / SLOT) % ng;
            @(negedge clk);
            chk("R1", 64'(grid_o), (gi == 0) ? 64'd1 : (gi == 1) ? 64'd2 : 64'd0);
            chk("R2", 64'(grid3_seg57_o),
                half ? 64'(win(p, code) & disp_bits[SEGN + (SEGN + 1) * gi]) : 64'(gi == 2));
            chk(rq, 64'(seg_o & ~m), 64'(exp_row(p, gi, half, code, disp_bits) & ~m));
            if (g != 4'd0) chk("R7", 64'(seg_o & m), 64'(disp_bits[SEGN-1:0] & m));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [SEGN-1:0] m;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", 64'({grid_o, grid3_seg57_o}), 64'd0);
        chk("R10", 64'(seg_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", 64'({grid_o, grid3_seg57_o, |seg_o}), 64'd0);

        for (int h = 0; h < 2; h++)
            for (int c = 0; c < (1 << DW); c++)
                sweep(h[0], c, 4'(c));

        // R8: sleep mid-slot, GP pins keep driving, restart on exit
        sweep(1'b0, 9, 4'b0101);
        m = gpmask(4'b0101);
        @(negedge clk);
        sleep = 1'b1;
        @(negedge clk);
        chk("R8", 64'({grid_o, grid3_seg57_o}), 64'd0);
        chk("R8", 64'(seg_o & ~m), 64'd0);
        chk("R7", 64'(seg_o & m), 64'(disp_bits[SEGN-1:0] & m));
        repeat (5) @(negedge clk);
        chk("R8", 64'(seg_o & ~m), 64'd0);
        sleep = 1'b0;
        @(negedge clk);
        chk("R8", 64'(grid_o), 64'd1);
        chk("R8", 64'(seg_o & ~m), 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R8", 64'(seg_o & ~m), 64'(exp_row(2, 0, 1'b0, 9, disp_bits) & ~m));

        // R9: blank clears everything including GP pins
        blank_n = 1'b0;
        @(negedge clk);
        chk("R9", 64'({grid_o, grid3_seg57_o}), 64'd0);
        chk("R9", 64'(seg_o), 64'd0);
        blank_n = 1'b1;
        @(negedge clk);
        chk("R9", 64'(grid_o), 64'd1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule